// File: doc/BRIEF.md
# Prioritized Interrupt Vector Unit

This unit arbitrates interrupt sources for an 8-bit processor core with a 16-bit address space. It watches two active-low request pins, one maskable (`irqN`) and one non-maskable (`nmiN`), and a software-interrupt request (`swiReq`) driven by the instruction decoder. At each instruction boundary it selects the winning source and then presents the two addresses from which the core reads the handler start address: the high byte first, then the low byte. The core's sequencer steps through them with `vecStep`.

The unit owns the interrupt mask bit. Software can set or clear it through dedicated strobes. The unit sets it itself whenever it begins servicing a source, so a maskable request that is still asserted does not re-enter the handler. The unit also drives a two-bit bus status code. The core uses this code to show whether it is running normally, acknowledging an interrupt or reset, waiting for a synchronizing event, or halted.

Top module: `ivu_top`

## Requirements
- R1: A source is taken only on a clock edge where `instrEnd` is 1 and no vector fetch is in progress. Without `instrEnd`, a pending request starts no fetch.
- R2: When several sources are present at a boundary, the non-maskable request wins. The software interrupt comes next and the maskable request comes last.
- R3: The vector pair addresses are 0xFFFC/0xFFFD for the non-maskable request, 0xFFFA/0xFFFB for the software interrupt and 0xFFF8/0xFFF9 for the maskable request. `vecValid` rises the cycle after the boundary edge and `vecAddr` shows the high-byte address. After one `vecStep` edge, `vecAddr` shows the low-byte address. After a second `vecStep` edge, `vecValid` returns to 0.
- R4: When `maskI` is 1, a low `irqN` is ignored and no fetch starts. When `maskI` is 0, a low `irqN` at a boundary is serviced.
- R5: The non-maskable request is latched on a falling edge of `nmiN`, whatever the value of `maskI`. It stays pending, including across a fetch already in progress, until its own fetch starts. Holding `nmiN` low raises no further request.
- R6: `maskI` is 1 after reset. A `maskSet` edge sets it and a `maskClr` edge clears it. The start of any service sets it, and this takes precedence over `maskClr`.
- R7: `busStatus` is 01 while reset is asserted and while `vecValid` is 1. Otherwise it is 11 when `haltAck` is 1, 10 when `syncAck` is 1, and 00 when neither is set.
- R8: After reset, `vecValid` is 0 and no non-maskable request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqN | input | 1 | Maskable request, active low, level sampled |
| nmiN | input | 1 | Non-maskable request, active low, falling-edge latched |
| swiReq | input | 1 | Software interrupt request from the decoder |
| instrEnd | input | 1 | Instruction boundary; sources are sampled here |
| vecStep | input | 1 | Core has consumed the current vector byte |
| maskSet | input | 1 | Set the mask bit |
| maskClr | input | 1 | Clear the mask bit |
| haltAck | input | 1 | Core is halted |
| syncAck | input | 1 | Core is waiting for a synchronizing event |
| vecValid | output | 1 | A vector fetch is in progress |
| vecAddr | output | 16 | Address of the vector byte to read |
| maskI | output | 1 | Current interrupt mask bit |
| busStatus | output | 2 | Bus status code |

## Verification
The bench targets the simultaneous-source cases. A design with a swapped priority would fetch the software or maskable vector while a non-maskable edge was pending. It also holds `irqN` low after a service. A unit that does not set the mask on entry would re-enter the maskable handler at every boundary. A held-low `nmiN` and an `nmiN` edge that arrives mid-fetch cover edge detection: a level-sensitive design retriggers, and a design that drops the edge never services it. Bus status is checked during reset, during a fetch while `haltAck` is set, and with `haltAck` and `syncAck` both set, which exposes any wrong ordering of the status codes.

// File: rtl/ivu_pkg.sv
package ivu_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_IRQ  = 2'd1,
    SRC_SWI  = 2'd2,
    SRC_NMI  = 2'd3
  } ivuSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    start;    // service begins on this edge
    ivuSrc_t src;      // winning source when start is set
    logic    lowByte;  // second byte of the vector pair
    logic    busy;     // vector fetch in progress
  } ivuStrobe_t;

  localparam logic [1:0] BS_RUN    = 2'b00;
  localparam logic [1:0] BS_INTACK = 2'b01;
  localparam logic [1:0] BS_SYNC   = 2'b10;
  localparam logic [1:0] BS_HALT   = 2'b11;

endpackage

// File: rtl/ivu_ctrl.sv
module ivu_ctrl
  import ivu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrEnd,
  input  logic       swiReq,
  input  logic       irqN,
  input  logic       vecStep,
  input  logic       nmiPend,
  input  logic       maskI,
  output ivuStrobe_t strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_HI, ST_LO} ivuState_t;

  ivuState_t state, stateNext;
  ivuSrc_t   pick;
  logic      irqLive;

  // fixed priority: non-maskable, software, maskable
  always_comb begin
    irqLive = !irqN && !maskI;
    if (nmiPend)      pick = SRC_NMI;
    else if (swiReq)  pick = SRC_SWI;
    else if (irqLive) pick = SRC_IRQ;
    else              pick = SRC_NONE;
  end

  always_comb begin
    strobe.start   = (state == ST_IDLE) && instrEnd && (pick != SRC_NONE);
    strobe.src     = pick;
    strobe.lowByte = (state == ST_LO);
    strobe.busy    = (state != ST_IDLE);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (strobe.start) stateNext = ST_HI;
      ST_HI:   if (vecStep)      stateNext = ST_LO;
      ST_LO:   if (vecStep)      stateNext = ST_IDLE;
      default:                   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_START_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.busy) |-> $past(instrEnd)); // R1

  AST_MASKED_IRQ_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(strobe.busy) && $past(maskI)) |-> $past(nmiPend || swiReq)); // R4

  AST_LOW_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.lowByte) |-> ($past(strobe.busy) && $past(vecStep))); // R3

endmodule

// File: rtl/ivu_dp.sv
module ivu_dp
  import ivu_pkg::*;
#(
  parameter int unsigned        ADDR_W  = 16,
  parameter logic [ADDR_W-1:0]  VEC_IRQ = 16'hFFF8,
  parameter logic [ADDR_W-1:0]  VEC_SWI = 16'hFFFA,
  parameter logic [ADDR_W-1:0]  VEC_NMI = 16'hFFFC
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiN,
  input  logic              maskSet,
  input  logic              maskClr,
  input  logic              haltAck,
  input  logic              syncAck,
  input  ivuStrobe_t        strobe,
  output logic              nmiPend,
  output logic              maskI,
  output logic [ADDR_W-1:0] vecAddr,
  output logic [1:0]        busStatus
);

  logic              nmiPrev;
  logic              nmiFall;
  logic              nmiTaken;
  logic [ADDR_W-1:0] vecBase;

  assign nmiFall  = nmiPrev && !nmiN;
  assign nmiTaken = strobe.start && (strobe.src == SRC_NMI);

  // edge latch for the non-maskable pin; a fresh edge outranks the clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiPrev <= 1'b1;
      nmiPend <= 1'b0;
    end else begin
      nmiPrev <= nmiN;
      nmiPend <= (nmiPend && !nmiTaken) || nmiFall;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       maskI <= 1'b1;
    else if (strobe.start || maskSet) maskI <= 1'b1;
    else if (maskClr)                maskI <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vecBase <= '0;
    else if (strobe.start) begin
      unique case (strobe.src)
        SRC_NMI: vecBase <= VEC_NMI;
        SRC_SWI: vecBase <= VEC_SWI;
        default: vecBase <= VEC_IRQ;
      endcase
    end
  end

  assign vecAddr = vecBase + ADDR_W'(strobe.lowByte);

  always_comb begin
    if (!rstN || strobe.busy) busStatus = BS_INTACK;
    else if (haltAck)         busStatus = BS_HALT;
    else if (syncAck)         busStatus = BS_SYNC;
    else                      busStatus = BS_RUN;
  end

  AST_MASK_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> maskI); // R6

  AST_ACK_WHILE_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.busy |-> (busStatus == BS_INTACK)); // R7

  AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.start && nmiPend) |-> (strobe.src == SRC_NMI)); // R2

  AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (nmiPend && !nmiTaken) |=> nmiPend); // R5

endmodule

// File: rtl/ivu_top.sv
module ivu_top
  import ivu_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] VEC_IRQ = 16'hFFF8,
  parameter logic [ADDR_W-1:0] VEC_SWI = 16'hFFFA,
  parameter logic [ADDR_W-1:0] VEC_NMI = 16'hFFFC
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqN,
  input  logic              nmiN,
  input  logic              swiReq,
  input  logic              instrEnd,
  input  logic              vecStep,
  input  logic              maskSet,
  input  logic              maskClr,
  input  logic              haltAck,
  input  logic              syncAck,
  output logic              vecValid,
  output logic [ADDR_W-1:0] vecAddr,
  output logic              maskI,
  output logic [1:0]        busStatus
);

  ivuStrobe_t strobe;
  logic       nmiPend;

  ivu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .instrEnd (instrEnd),
    .swiReq   (swiReq),
    .irqN     (irqN),
    .vecStep  (vecStep),
    .nmiPend  (nmiPend),
    .maskI    (maskI),
    .strobe   (strobe)
  );

  ivu_dp #(
    .ADDR_W  (ADDR_W),
    .VEC_IRQ (VEC_IRQ),
    .VEC_SWI (VEC_SWI),
    .VEC_NMI (VEC_NMI)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .nmiN      (nmiN),
    .maskSet   (maskSet),
    .maskClr   (maskClr),
    .haltAck   (haltAck),
    .syncAck   (syncAck),
    .strobe    (strobe),
    .nmiPend   (nmiPend),
    .maskI     (maskI),
    .vecAddr   (vecAddr),
    .busStatus (busStatus)
  );

  assign vecValid = strobe.busy;

endmodule

// File: tb/ivu_top_tb.sv
`timescale 1ns/1ps
module ivu_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irqN = 1'b1, nmiN = 1'b1, swiReq = 1'b0, instrEnd = 1'b0;
  logic        vecStep = 1'b0, maskSet = 1'b0, maskClr = 1'b0;
  logic        haltAck = 1'b0, syncAck = 1'b0;
  logic        vecValid, maskI;
  logic [15:0] vecAddr;
  logic [1:0]  busStatus;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  ivu_top u_dut (
    .clk(clk), .rstN(rstN), .irqN(irqN), .nmiN(nmiN), .swiReq(swiReq),
    .instrEnd(instrEnd), .vecStep(vecStep), .maskSet(maskSet),
    .maskClr(maskClr), .haltAck(haltAck), .syncAck(syncAck),
    .vecValid(vecValid), .vecAddr(vecAddr), .maskI(maskI),
    .busStatus(busStatus)
  );

  // entry: {clearMask, irqLow, nmiEdge, swi, expValid, expAddr[15:0]}
  localparam int NV = 8;
  localparam logic [20:0] TBL [NV] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFFF8},  // R3 R4 unmasked irq
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000},  // R4 masked irq ignored
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'hFFFC},  // R5 nmi despite mask
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'hFFFA},  // R3 swi
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'hFFFC},  // R2 all three
    {1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'hFFFA},  // R2 swi over irq
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000},  // R1 nothing pending
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'hFFFC}   // R2 nmi over masked irq
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic boundary();
    instrEnd = 1'b1; tick(); instrEnd = 1'b0;
  endtask

  task automatic step();
    vecStep = 1'b1; tick(); vecStep = 1'b0;
  endtask

  task automatic pulseClr();
    maskClr = 1'b1; tick(); maskClr = 1'b0;
  endtask

  task automatic pulseSet();
    maskSet = 1'b1; tick(); maskSet = 1'b0;
  endtask

  // checks both vector bytes and the return to idle
  task automatic fetchPair(input string tag, input logic [15:0] base);
    chk({tag, " hi valid"}, 32'(vecValid), 32'd1);
    chk({tag, " hi addr R3"}, 32'(vecAddr), 32'(base));
    chk({tag, " mask R6"}, 32'(maskI), 32'd1);
    chk({tag, " status R7"}, 32'(busStatus), 32'd1);
    step();
    chk({tag, " lo addr R3"}, 32'(vecAddr), 32'(base + 16'd1));
    step();
    chk({tag, " idle R3"}, 32'(vecValid), 32'd0);
  endtask

  initial begin : watchdog
    #(5.0 * 100000);
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    // reset state R8 R7 R6
    repeat (3) @(negedge clk);
    chk("R7 status in reset", 32'(busStatus), 32'd1);
    chk("R8 valid in reset", 32'(vecValid), 32'd0);
    chk("R6 mask in reset", 32'(maskI), 32'd1);
    rstN = 1'b1;
    tick();
    chk("R7 run status", 32'(busStatus), 32'd0);
    swiReq = 1'b0;
    boundary();
    chk("R8 no pending nmi after reset", 32'(vecValid), 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [20:0] e;
      e = TBL[i];
      if (e[20]) pulseClr(); else pulseSet();
      irqN = !e[19];
      swiReq = e[17];
      if (e[18]) begin nmiN = 1'b0; tick(); end
      boundary();
      swiReq = 1'b0;
      if (e[16]) fetchPair($sformatf("R2 R3 entry %0d", i), e[15:0]);
      else begin
        chk($sformatf("R1 R4 entry %0d no fetch", i), 32'(vecValid), 32'd0);
        chk($sformatf("R7 entry %0d status", i), 32'(busStatus), 32'd0);
      end
      irqN = 1'b1; nmiN = 1'b1;
      tick();
    end

    // R1: no boundary, no service
    pulseClr();
    irqN = 1'b0;
    repeat (3) tick();
    chk("R1 no boundary no fetch", 32'(vecValid), 32'd0);
    boundary();
    fetchPair("R1 irq at boundary", 16'hFFF8);
    // R6/R4: mask set on entry blocks re-entry
    boundary();
    chk("R6 held irq blocked after entry", 32'(vecValid), 32'd0);
    pulseClr();
    chk("R6 mask cleared", 32'(maskI), 32'd0);
    boundary();
    fetchPair("R4 irq after clear", 16'hFFF8);
    irqN = 1'b1;

    // R6: service start outranks clear
    swiReq = 1'b1; maskClr = 1'b1; instrEnd = 1'b1;
    tick();
    instrEnd = 1'b0; maskClr = 1'b0; swiReq = 1'b0;
    chk("R6 start beats clear", 32'(maskI), 32'd1);
    step(); step();

    // R5: level held low does not retrigger
    nmiN = 1'b0; tick();
    boundary();
    fetchPair("R5 nmi edge", 16'hFFFC);
    boundary();
    chk("R5 held low no retrigger", 32'(vecValid), 32'd0);
    nmiN = 1'b1; tick();

    // R5: edge during another fetch stays pending
    swiReq = 1'b1; boundary(); swiReq = 1'b0;
    chk("R5 swi fetch addr", 32'(vecAddr), 32'hFFFA);
    nmiN = 1'b0; tick(); nmiN = 1'b1;
    // R7: halt during fetch still reports acknowledge
    haltAck = 1'b1; tick();
    chk("R7 ack over halt", 32'(busStatus), 32'd1);
    haltAck = 1'b0;
    step(); step();
    chk("R5 back to idle", 32'(vecValid), 32'd0);
    boundary();
    fetchPair("R5 nmi kept pending", 16'hFFFC);

    // R7 status ordering
    haltAck = 1'b1; tick();
    chk("R7 halt", 32'(busStatus), 32'd3);
    syncAck = 1'b1; tick();
    chk("R7 halt over sync", 32'(busStatus), 32'd3);
    haltAck = 1'b0; tick();
    chk("R7 sync", 32'(busStatus), 32'd2);
    syncAck = 1'b0; tick();
    chk("R7 run", 32'(busStatus), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule